// File: doc/BRIEF.md
# Double-Precision Floating-Point Comparator

This unit compares two 64-bit IEEE-754 double-precision values. It returns a one-hot, four-bit condition code that says whether the first operand is below, above, equal to, or unordered with the second. It also keeps a small set of floating-point status bits up to date. Both operands are classified bit by bit, with no arithmetic. An operand is a NaN when its exponent field is all ones and its fraction is nonzero. A NaN is signaling when the top fraction bit is clear. All other values are ordered through a monotonic integer key built from their sign-magnitude encoding, and the two zeros are treated as equal.

A compare is started by pulsing `op_valid` with the operands and the mode. The result appears, registered, one cycle later together with `res_valid`. The mode bit selects between a quiet (unordered) compare and a signaling (ordered) compare. The two modes update different sticky invalid-operation bits. The signaling-NaN path also depends on whether invalid-operation exceptions are currently enabled. The status bits persist across compares until `status_clear` or reset clears them.

Top module: `fp_compare_unit`

## Requirements
- R1: One cycle after a cycle with `op_valid` high, `res_valid` is high and `cond_code` holds exactly one of 4'h8 (a < b), 4'h4 (a > b), 4'h2 (a == b) or 4'h1 (unordered). In any other cycle `res_valid` is low.
- R2: An operand whose bits [62:52] are all ones and whose bits [51:0] are nonzero is a NaN, and any compare involving a NaN yields 4'h1. Infinities (fraction zero) compare as ordinary ordered values.
- R3: Non-NaN operands are ordered by value, including denormals and infinities, and +0 and -0 compare equal (4'h2).
- R4: Each compare writes its condition code into `cond_field`, which holds that value until the next compare or a clear.
- R5: An unordered result sets `sum_invalid`.
- R6: In quiet mode (`ordered_mode` = 0), an unordered result sets `snan_invalid`.
- R7: In ordered mode (`ordered_mode` = 1), a compare first clears `sum_invalid`, so an ordered compare with no NaN leaves it 0.
- R8: In ordered mode, a NaN operand sets `cmp_invalid` when neither operand is signaling. When a signaling NaN (bit 51 = 0) is present, it sets `snan_invalid`, and it sets `cmp_invalid` only if `inv_enable` is 0.
- R9: `snan_invalid` and `cmp_invalid` are sticky: no compare clears them. `status_clear` zeroes `cond_field`, `sum_invalid`, `snan_invalid` and `cmp_invalid` on the next edge and overrides a status update from the same cycle. The condition code of that same-cycle compare is still produced.
- R10: While reset is asserted and after it, before any compare, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Starts a compare of the operands presented this cycle |
| ordered_mode | input | 1 | 1 = ordered (signaling) compare, 0 = quiet compare |
| inv_enable | input | 1 | Invalid-operation exceptions enabled |
| status_clear | input | 1 | Clears the status bits and the condition field |
| opnd_a | input | 64 | First operand, IEEE-754 double |
| opnd_b | input | 64 | Second operand, IEEE-754 double |
| res_valid | output | 1 | Result valid, one cycle after `op_valid` |
| cond_code | output | 4 | One-hot compare result |
| cond_field | output | 4 | Status copy of the last condition code |
| sum_invalid | output | 1 | Invalid-operation summary status |
| snan_invalid | output | 1 | Signaling-NaN invalid status (sticky) |
| cmp_invalid | output | 1 | Invalid-compare status (sticky) |

## Verification
The assertions assume that `rst_n` is held low for at least one edge and that `ordered_mode`, `inv_enable` and `status_clear` are meaningful only in the cycle they are sampled with `op_valid`. Under that assumption they can compare a result against the mode captured one cycle earlier. The stimulus drives every input on the falling edge and holds it for a full cycle. It issues separate one-cycle compares and clears, covering zeros of both signs, infinities, denormals, quiet and signaling NaNs and random bit patterns in both modes and with both enable settings. It also includes one compare that coincides with a clear.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;

  typedef logic [3:0] cc_t;
  localparam cc_t CC_LT    = 4'h8;
  localparam cc_t CC_GT    = 4'h4;
  localparam cc_t CC_EQ    = 4'h2;
  localparam cc_t CC_UNORD = 4'h1;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic is_zero;
  } opclass_t;
endpackage

// File: rtl/fpc_classify.sv
module fpc_classify
  import fpc_pkg::*;
#(
  parameter int EXP_W  = DP_EXP_W,
  parameter int FRAC_W = DP_FRAC_W
) (
  input  logic [EXP_W+FRAC_W:0] word_i,
  output opclass_t              cls_o
);
  localparam int MAG_W = EXP_W + FRAC_W;

  function automatic opclass_t classify(input logic [MAG_W:0] w);
    opclass_t   c;
    logic       exp_ones;
    logic       frac_nz;
    exp_ones  = &w[MAG_W-1:FRAC_W];
    frac_nz   = |w[FRAC_W-1:0];
    c.is_nan  = exp_ones && frac_nz;
    c.is_snan = exp_ones && frac_nz && !w[FRAC_W-1];
    c.is_zero = ~|w[MAG_W-1:0];
    return c;
  endfunction

  assign cls_o = classify(word_i);
endmodule

// File: rtl/fpc_relation.sv
module fpc_relation
  import fpc_pkg::*;
#(
  parameter int EXP_W  = DP_EXP_W,
  parameter int FRAC_W = DP_FRAC_W
) (
  input  logic [EXP_W+FRAC_W:0] a_i,
  input  logic [EXP_W+FRAC_W:0] b_i,
  input  opclass_t              cls_a_i,
  input  opclass_t              cls_b_i,
  output cc_t                   cc_o,
  output logic                  unord_o
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  // Monotonic key: negative values flip all bits, positive ones flip sign.
  function automatic logic [WORD_W-1:0] order_key(input logic [WORD_W-1:0] w);
    return w[WORD_W-1] ? ~w : {1'b1, w[WORD_W-2:0]};
  endfunction

  function automatic cc_t relate(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b,
                                 input opclass_t ca, input opclass_t cb);
    logic [WORD_W-1:0] ka;
    logic [WORD_W-1:0] kb;
    ka = order_key(a);
    kb = order_key(b);
    if (ca.is_nan || cb.is_nan)          return CC_UNORD;
    else if (ca.is_zero && cb.is_zero)   return CC_EQ;
    else if (ka < kb)                    return CC_LT;
    else if (ka > kb)                    return CC_GT;
    else                                 return CC_EQ;
  endfunction

  assign cc_o    = relate(a_i, b_i, cls_a_i, cls_b_i);
  assign unord_o = cls_a_i.is_nan || cls_b_i.is_nan;
endmodule

// File: rtl/fpc_status.sv
module fpc_status
  import fpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic upd_i,
  input  logic clr_i,
  input  logic ordered_i,
  input  logic inv_en_i,
  input  logic unord_i,
  input  logic snan_seen_i,
  input  cc_t  cc_i,
  output cc_t  field_o,
  output logic sum_o,
  output logic snan_o,
  output logic cmp_o
);
  logic ev_set_sum;
  logic ev_set_snan;
  logic ev_set_cmp;

  assign ev_set_sum  = upd_i && unord_i;
  assign ev_set_snan = upd_i && unord_i && (!ordered_i || snan_seen_i);
  assign ev_set_cmp  = upd_i && ordered_i && unord_i && (!snan_seen_i || !inv_en_i);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      field_o <= '0;
      sum_o   <= 1'b0;
      snan_o  <= 1'b0;
      cmp_o   <= 1'b0;
    end else if (upd_i) begin
      field_o <= cc_i;
      if (ordered_i) sum_o <= ev_set_sum;
      else if (ev_set_sum) sum_o <= 1'b1;
      if (ev_set_snan) snan_o <= 1'b1;
      if (ev_set_cmp)  cmp_o  <= 1'b1;
    end
  end

  AST_STICKY_SNAN: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_i) && $past(snan_o) |-> snan_o); // R9
  AST_STICKY_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_i) && $past(cmp_o) |-> cmp_o); // R9
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (field_o == '0) && !sum_o && !snan_o && !cmp_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i && !clr_i |=> $stable(field_o) && $stable(sum_o)); // R4
endmodule

// File: rtl/fp_compare_unit.sv
module fp_compare_unit
  import fpc_pkg::*;
#(
  parameter int EXP_W  = DP_EXP_W,
  parameter int FRAC_W = DP_FRAC_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        op_valid,
  input  logic                        ordered_mode,
  input  logic                        inv_enable,
  input  logic                        status_clear,
  input  logic [EXP_W+FRAC_W:0]       opnd_a,
  input  logic [EXP_W+FRAC_W:0]       opnd_b,
  output logic                        res_valid,
  output logic [3:0]                  cond_code,
  output logic [3:0]                  cond_field,
  output logic                        sum_invalid,
  output logic                        snan_invalid,
  output logic                        cmp_invalid
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int N_OPND = 2;

  logic [WORD_W-1:0] opnd [N_OPND];
  opclass_t          cls  [N_OPND];
  logic [N_OPND-1:0] snan_vec;
  logic              snan_seen;
  logic              unord_now;
  cc_t               cc_next;

  assign opnd[0] = opnd_a;
  assign opnd[1] = opnd_b;

  for (genvar g = 0; g < N_OPND; g++) begin : g_cls
    fpc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .word_i (opnd[g]),
      .cls_o  (cls[g])
    );
    assign snan_vec[g] = cls[g].is_snan;
  end

  assign snan_seen = |snan_vec;

  fpc_relation #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_rel (
    .a_i     (opnd[0]),
    .b_i     (opnd[1]),
    .cls_a_i (cls[0]),
    .cls_b_i (cls[1]),
    .cc_o    (cc_next),
    .unord_o (unord_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      cond_code <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) cond_code <= cc_next;
    end
  end

  fpc_status u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_i       (op_valid),
    .clr_i       (status_clear),
    .ordered_i   (ordered_mode),
    .inv_en_i    (inv_enable),
    .unord_i     (unord_now),
    .snan_seen_i (snan_seen),
    .cc_i        (cc_next),
    .field_o     (cond_field),
    .sum_o       (sum_invalid),
    .snan_o      (snan_invalid),
    .cmp_o       (cmp_invalid)
  );

  AST_CC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $countones(cond_code) == 1); // R1
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid); // R1
  AST_FIELD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !$past(status_clear) |-> cond_field == cond_code); // R4
  AST_UNORD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && cond_code == CC_UNORD && !$past(status_clear) |-> sum_invalid); // R5
  AST_QUIET_SNAN: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !$past(ordered_mode) && cond_code == CC_UNORD && !$past(status_clear)
      |-> snan_invalid); // R6
  AST_ORD_SUM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && $past(ordered_mode) && cond_code != CC_UNORD |-> !sum_invalid); // R7
  AST_ORD_VXC: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && $past(ordered_mode) && !$past(inv_enable) && cond_code == CC_UNORD
      && !$past(status_clear) |-> cmp_invalid); // R8
  AST_SNAN_IMPLIES_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && snan_seen |=> cond_code == CC_UNORD); // R2
endmodule

// File: tb/test_fp_compare_unit.sv
module test_fp_compare_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  typedef struct {
    logic [3:0] cc;
    logic [3:0] field;
    logic       sum;
    logic       snan;
    logic       cmp;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        ordered_mode = 1'b0;
  logic        inv_enable = 1'b0;
  logic        status_clear = 1'b0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic        res_valid;
  logic [3:0]  cond_code;
  logic [3:0]  cond_field;
  logic        sum_invalid;
  logic        snan_invalid;
  logic        cmp_invalid;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;
  exp_t sb_q[$];

  // bench copy of the status state
  logic [3:0] m_field = '0;
  logic       m_sum = 1'b0, m_snan = 1'b0, m_cmp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_compare_unit i_fp_compare_unit (
    .clk, .rst_n, .op_valid, .ordered_mode, .inv_enable, .status_clear,
    .opnd_a, .opnd_b, .res_valid, .cond_code, .cond_field,
    .sum_invalid, .snan_invalid, .cmp_invalid
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit nan_of(input logic [63:0] x);
    return (x[62:52] == 11'h7ff) && (x[51:0] != 52'd0);
  endfunction

  function automatic bit sig_of(input logic [63:0] x);
    return nan_of(x) && (x[51] == 1'b0);
  endfunction

  function automatic logic [3:0] ref_cc(input logic [63:0] a, input logic [63:0] b);
    real ra, rb;
    if (nan_of(a) || nan_of(b)) return 4'h1;     // R2
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    if (ra < rb) return 4'h8;                     // R3
    if (ra > rb) return 4'h4;
    return 4'h2;
  endfunction

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input bit ord,
                       input bit ien, input bit clr, input string tag);
    exp_t e;
    bit   un, sg;
    @(negedge clk);
    opnd_a = a; opnd_b = b; ordered_mode = ord; inv_enable = ien;
    status_clear = clr; op_valid = 1'b1;
    e.cc = ref_cc(a, b);
    un = (e.cc == 4'h1);
    sg = sig_of(a) || sig_of(b);
    if (clr) begin
      m_field = '0; m_sum = 0; m_snan = 0; m_cmp = 0;
    end else begin
      m_field = e.cc;
      if (ord) m_sum = 1'b0;
      if (un) m_sum = 1'b1;
      if (un && (!ord || sg)) m_snan = 1'b1;
      if (un && ord && (!sg || !ien)) m_cmp = 1'b1;
    end
    e.field = m_field; e.sum = m_sum; e.snan = m_snan; e.cmp = m_cmp; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    op_valid = 1'b0; status_clear = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    status_clear = 1'b1;
    m_field = '0; m_sum = 0; m_snan = 0; m_cmp = 0;
    @(negedge clk);
    status_clear = 1'b0;
    check({cond_field, sum_invalid, snan_invalid, cmp_invalid} == 7'd0, "R9",
          "clear", {9'd0, cond_field, sum_invalid, snan_invalid, cmp_invalid}, 16'd0);
  endtask

  // monitor: pop and compare whenever a result is produced
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R1", "unexpected res_valid", 16'd1, 16'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(cond_code == e.cc, "R1", {e.tag, " cc"}, {12'd0, cond_code}, {12'd0, e.cc});
        check(cond_field == e.field, "R4", {e.tag, " field"},
              {12'd0, cond_field}, {12'd0, e.field});
        check({sum_invalid, snan_invalid, cmp_invalid} == {e.sum, e.snan, e.cmp},
              "R5", {e.tag, " status(R6 R7 R8 R9)"},
              {13'd0, sum_invalid, snan_invalid, cmp_invalid}, {13'd0, e.sum, e.snan, e.cmp});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      check(1'b0, "R1", "watchdog expired", 16'd0, 16'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  localparam logic [63:0] P_ZERO = 64'h0000_0000_0000_0000;
  localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] P_INF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] N_INF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN   = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN   = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] N_SNAN = 64'hFFF4_0000_0000_0000;
  localparam logic [63:0] P_DEN  = 64'h0000_0000_0000_0001;
  localparam logic [63:0] N_DEN  = 64'h8000_0000_0000_0001;
  localparam logic [63:0] ONE    = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] N_ONE  = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] P_MAX  = 64'h7FEF_FFFF_FFFF_FFFF;

  initial begin
    logic [63:0] specials [12];
    specials = '{P_ZERO, N_ZERO, P_INF, N_INF, QNAN, SNAN, N_SNAN,
                 P_DEN, N_DEN, ONE, N_ONE, P_MAX};
    repeat (3) @(negedge clk);
    // R10: reset state
    check({res_valid, cond_code, cond_field, sum_invalid, snan_invalid, cmp_invalid} == 12'd0,
          "R10", "reset outputs",
          {4'd0, res_valid, cond_code, cond_field, sum_invalid, snan_invalid, cmp_invalid}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check({res_valid, cond_field, sum_invalid} == 6'd0, "R10", "after reset",
          {10'd0, res_valid, cond_field, sum_invalid}, 16'd0);

    drive(P_ZERO, N_ZERO, 1'b0, 1'b0, 1'b0, "R3 +0 vs -0");
    drive(N_DEN, P_DEN, 1'b1, 1'b0, 1'b0, "R3 denormals");
    drive(P_INF, P_MAX, 1'b1, 1'b0, 1'b0, "R2 inf ordered");
    drive(N_INF, N_INF, 1'b0, 1'b0, 1'b0, "R2 inf equal");
    drive(ONE, QNAN, 1'b0, 1'b0, 1'b0, "R6 quiet unordered");
    drive(ONE, N_ONE, 1'b1, 1'b0, 1'b0, "R7 ordered clears sum");
    do_clear();
    drive(QNAN, ONE, 1'b1, 1'b1, 1'b0, "R8 ordered qnan");
    do_clear();
    drive(SNAN, ONE, 1'b1, 1'b1, 1'b0, "R8 snan enabled");
    drive(ONE, N_SNAN, 1'b1, 1'b0, 1'b0, "R8 snan disabled");
    drive(N_ONE, ONE, 1'b1, 1'b0, 1'b0, "R9 sticky after ordered");
    drive(QNAN, SNAN, 1'b0, 1'b0, 1'b1, "R9 clear with compare");

    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        drive(specials[i], specials[j], 1'((i + j) % 2), 1'(j % 3 == 0), 1'b0, "R2 special pair");

    for (int k = 0; k < 400; k++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (k % 4 == 1) b[62:52] = a[62:52];
      if (k % 4 == 2) b = a;
      if (k % 16 == 3) a[62:52] = 11'h7ff;
      drive(a, b, 1'($urandom % 2), 1'($urandom % 2), 1'(k % 37 == 0), "R3 random pair");
      if (k % 50 == 49) do_clear();
    end

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R1", "results outstanding", 16'(sb_q.size()), 16'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule